// File: doc/BRIEF.md
# Peak and hold solenoid current controller

This block is the digital core of a high-side solenoid driver. Each actuation first regulates the load current to a peak level and then to a lower hold level. The analog front end is outside the block. It hands over one comparator bit that says whether the sampled load current is below the reference the block currently presents. The block chooses that reference from two programmable threshold pairs, and each pair has a lower and an upper 7-bit level. It toggles the high-side gate command and the freewheel clamp command so that the current swings between the two levels of the active pair.

The switch from the peak pair to the hold pair has two sources, and a register bit chooses between them. In clock mode, the start of an actuation loads an 8-bit dwell count. The count steps down on each rising edge of an external dwell clock, and the hold pair takes over when it runs out. In level mode, the same pin selects the pair directly. When both enable inputs are high, an actuation runs. Removing either one kills the gate at once and returns the block to idle. A programmable dead gap separates the gate and clamp commands, and it is never shorter than one clock.

Top module: `pk_hold_ctrl`

## Requirements
- R1: After reset, gate_o and clamp_o are low, ref_o is 0 and loop_o is high while cur_below_i is low.
- R2: gate_o is high only while ena_i and ctl_i are both high. Dropping either input drives gate_o low in the same cycle, with no clock edge needed.
- R3: Register writes go to wr_addr_i: 0 is the peak lower level, 2 the peak upper level, 3 the hold lower level, 4 the hold upper level (bits 6:0 each), and 5 the dwell count (bits 7:0). Address 1 is the mode register. Its bit 3 selects the pair-switch source, 0 for clock mode and 1 for level mode, and bits 2:0 set the dead gap. After reset, bit 3 is 0, so clock mode is the default.
- R4: In clock mode, an actuation starts on the peak pair and loads the dwell count. Each synchronized rising edge of pclk_i lowers the count by one. The block moves to the hold pair once the count is zero and stays there until the actuation ends. A dwell count of 0 goes to the hold pair straight away.
- R5: In level mode, while an actuation runs, pclk_i high selects the peak pair and pclk_i low selects the hold pair.
- R6: ref_o presents the upper level of the active pair while a gate request is pending and the lower level otherwise. A gate request is raised when cur_below_i is high and cleared when it is low. While a request is pending the clamp is off, and with no request the clamp is on.
- R7: When the drive passes from gate to clamp or from clamp to gate, both commands stay low for exactly (mode register bits 2:0) + 1 clock cycles.
- R8: gate_o and clamp_o are never high in the same cycle.
- R9: loop_o equals the inverse of cur_below_i, delayed by SYNC_STAGES clock cycles.
- R10: When an actuation ends, the sequencer returns to idle, the dwell timer is cleared and both commands go low. The next actuation begins on the peak pair again with the full dwell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ena_i | input | 1 | Enable, ANDed with ctl_i |
| ctl_i | input | 1 | Actuation command, ANDed with ena_i |
| pclk_i | input | 1 | Dwell clock (clock mode) or pair select (level mode) |
| cur_below_i | input | 1 | Comparator result: load current below ref_o |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| gate_o | output | 1 | High-side gate command |
| clamp_o | output | 1 | Freewheel clamp command |
| ref_o | output | 7 | Reference level for the current comparator |
| loop_o | output | 1 | Loop state, low when current is below the reference |

## Verification
The bench uses the default parameters: a two-stage input synchronizer, 7-bit thresholds, an 8-bit dwell counter and a 3-bit dead-gap field. With these values it can measure the dead gap exactly at both its minimum and a larger setting in both switching directions. It also counts a short dwell edge by edge, so the last decrement before the peak-to-hold switch is seen. The exact two-cycle delay of the loop output can be timed directly, and the default clock mode can be told apart from level mode by holding the dwell pin high with a zero dwell count.

// File: rtl/pkh_pkg.sv
package pkh_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PEAK, SEQ_HOLD} seq_e;
  typedef enum logic [1:0] {DRV_OFF, DRV_GATE, DRV_CLAMP, DRV_DEAD} drv_e;

  localparam int unsigned ADDR_PEAK_LO = 0;
  localparam int unsigned ADDR_MODE    = 1;
  localparam int unsigned ADDR_PEAK_HI = 2;
  localparam int unsigned ADDR_HOLD_LO = 3;
  localparam int unsigned ADDR_HOLD_HI = 4;
  localparam int unsigned ADDR_DWELL   = 5;
  localparam int unsigned MODE_SEL_BIT = 3;
endpackage

// File: rtl/pkh_sync.sv
module pkh_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = chain_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= stage_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pkh_regs.sv
module pkh_regs
  import pkh_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TH_W    = 7,
  parameter int unsigned DWELL_W = 8,
  parameter int unsigned DT_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [TH_W-1:0]    peak_lo_o,
  output logic [TH_W-1:0]    peak_hi_o,
  output logic [TH_W-1:0]    hold_lo_o,
  output logic [TH_W-1:0]    hold_hi_o,
  output logic [DWELL_W-1:0] dwell_o,
  output logic               lvl_mode_o,
  output logic [DT_W-1:0]    dead_o
);
  localparam int unsigned NUM_TH = 4;
  localparam logic [ADDR_W-1:0] TH_ADDR [NUM_TH] = '{
    ADDR_W'(ADDR_PEAK_LO), ADDR_W'(ADDR_PEAK_HI),
    ADDR_W'(ADDR_HOLD_LO), ADDR_W'(ADDR_HOLD_HI)};

  logic [TH_W-1:0] th_q [NUM_TH];
  logic            mode_we, dwell_we;

  assign mode_we  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MODE));
  assign dwell_we = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_DWELL));

  for (genvar t = 0; t < NUM_TH; t++) begin : g_th
    logic th_we;
    assign th_we = wr_en_i && (wr_addr_i == TH_ADDR[t]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    th_q[t] <= '0;
      else if (th_we) th_q[t] <= wr_data_i[TH_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_mode_o <= 1'b0;
      dead_o     <= '0;
    end else if (mode_we) begin
      lvl_mode_o <= wr_data_i[MODE_SEL_BIT];
      dead_o     <= wr_data_i[DT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dwell_o <= '0;
    else if (dwell_we) dwell_o <= wr_data_i[DWELL_W-1:0];
  end

  assign peak_lo_o = th_q[0];
  assign peak_hi_o = th_q[1];
  assign hold_lo_o = th_q[2];
  assign hold_hi_o = th_q[3];
endmodule

// File: rtl/pkh_seq.sv
module pkh_seq
  import pkh_pkg::*;
#(
  parameter int unsigned DWELL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               pclk_i,
  input  logic               lvl_mode_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output seq_e               state_o
);
  seq_e               state_q, state_d;
  logic [DWELL_W-1:0] cnt_q, cnt_d;
  logic               pclk_q, pclk_rise, cnt_en;

  assign pclk_rise = pclk_i && !pclk_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!en_i) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (lvl_mode_i) begin
      state_d = pclk_i ? SEQ_PEAK : SEQ_HOLD;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          state_d = SEQ_PEAK;
          cnt_d   = dwell_i;
          cnt_en  = 1'b1;
        end
        SEQ_PEAK: begin
          if (cnt_q == '0) begin
            state_d = SEQ_HOLD;
          end else if (pclk_rise) begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: state_d = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      pclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pclk_q  <= pclk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state_o = state_q;

  // R10: timer is empty whenever the sequencer rests in idle
  p_idle_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE) |-> (cnt_q == '0));

  // R4: in clock mode the hold phase is kept until the actuation ends
  p_hold_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_HOLD && en_i && !lvl_mode_i) |=> (state_q == SEQ_HOLD));

  // R4: a running dwell count keeps the peak phase
  p_peak_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_PEAK && en_i && !lvl_mode_i && cnt_q != '0) |=> (state_q == SEQ_PEAK));
endmodule

// File: rtl/pkh_drive.sv
module pkh_drive
  import pkh_pkg::*;
#(
  parameter int unsigned DT_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            below_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            greq_o,
  output logic            gate_cmd_o,
  output logic            clamp_cmd_o
);
  drv_e            ph_q, ph_d, want;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en, greq_q;

  // The hysteresis band comes from the reference switching with greq:
  // below the lower level raises the request, above the upper clears it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) greq_q <= 1'b0;
    else         greq_q <= active_i && below_i;
  end

  always_comb begin
    if (!active_i)   want = DRV_OFF;
    else if (greq_q) want = DRV_GATE;
    else             want = DRV_CLAMP;
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (ph_q)
      DRV_OFF: ph_d = want;
      DRV_GATE, DRV_CLAMP: begin
        if (want != ph_q) begin
          ph_d   = DRV_DEAD;
          cnt_d  = dead_i;
          cnt_en = 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          ph_d = want;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= DRV_OFF;
    else         ph_q <= ph_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign greq_o      = greq_q;
  assign gate_cmd_o  = (ph_q == DRV_GATE);
  assign clamp_cmd_o = (ph_q == DRV_CLAMP);

  // R8: the two commands never overlap
  p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_cmd_o && clamp_cmd_o));

  // R7: the gate only starts after a cycle with the clamp off
  p_gate_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_cmd_o) |-> $past(!clamp_cmd_o));

  // R7: the clamp only starts after a cycle with the gate off
  p_clamp_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_cmd_o) |-> $past(!gate_cmd_o));
endmodule

// File: rtl/pk_hold_ctrl.sv
module pk_hold_ctrl
  import pkh_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TH_W        = 7,
  parameter int unsigned DWELL_W     = 8,
  parameter int unsigned DT_W        = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ena_i,
  input  logic              ctl_i,
  input  logic              pclk_i,
  input  logic              cur_below_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              gate_o,
  output logic              clamp_o,
  output logic [TH_W-1:0]   ref_o,
  output logic              loop_o
);
  localparam int unsigned NUM_SYNC = 4;
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_chain_q;
  logic                  rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_chain_q <= '0;
    else         rst_chain_q <= {rst_chain_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_chain_q[RST_STAGES-1];

  logic [NUM_SYNC-1:0] sync_q;
  logic                ena_s, ctl_s, pclk_s, below_s;

  pkh_sync #(.WIDTH(NUM_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({ena_i, ctl_i, pclk_i, cur_below_i}),
    .q_o   (sync_q)
  );
  assign {ena_s, ctl_s, pclk_s, below_s} = sync_q;

  logic [TH_W-1:0]    peak_lo, peak_hi, hold_lo, hold_hi;
  logic [DWELL_W-1:0] dwell;
  logic               lvl_mode;
  logic [DT_W-1:0]    dead;

  pkh_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TH_W(TH_W),
    .DWELL_W(DWELL_W), .DT_W(DT_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .peak_lo_o (peak_lo),
    .peak_hi_o (peak_hi),
    .hold_lo_o (hold_lo),
    .hold_hi_o (hold_hi),
    .dwell_o   (dwell),
    .lvl_mode_o(lvl_mode),
    .dead_o    (dead)
  );

  seq_e state;

  pkh_seq #(.DWELL_W(DWELL_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (ena_s && ctl_s),
    .pclk_i    (pclk_s),
    .lvl_mode_i(lvl_mode),
    .dwell_i   (dwell),
    .state_o   (state)
  );

  logic greq, gate_cmd, clamp_cmd;

  pkh_drive #(.DT_W(DT_W)) u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .active_i   (state != SEQ_IDLE),
    .below_i    (below_s),
    .dead_i     (dead),
    .greq_o     (greq),
    .gate_cmd_o (gate_cmd),
    .clamp_cmd_o(clamp_cmd)
  );

  always_comb begin
    if (state == SEQ_HOLD) ref_o = greq ? hold_hi : hold_lo;
    else                   ref_o = greq ? peak_hi : peak_lo;
  end

  // Enable inputs bypass the synchronizer so a drop kills the gate at once.
  assign gate_o  = gate_cmd && ena_i && ctl_i;
  assign clamp_o = clamp_cmd;
  assign loop_o  = !below_s;

  // R6: the drive only closes the gate after a request was raised
  p_gate_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(gate_cmd) |-> $past(greq));
endmodule

// File: tb/pk_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module pk_hold_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ena_i = 1'b0, ctl_i = 1'b0, pclk_i = 1'b0, cur_below_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       gate_o, clamp_o, loop_o;
  logic [6:0] ref_o;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;

  localparam int PK_LO = 10, PK_HI = 20, HD_LO = 4, HD_HI = 8;

  always #2 clk_i = ~clk_i;

  pk_hold_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ena_i(ena_i), .ctl_i(ctl_i),
    .pclk_i(pclk_i), .cur_below_i(cur_below_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .gate_o(gate_o),
    .clamp_o(clamp_o), .ref_o(ref_o), .loop_o(loop_o)
  );

  always @(negedge clk_i) if (rst_ni && gate_o && clamp_o) overlaps++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_pclk();
    pclk_i = 1'b1; cycles(4);
    pclk_i = 1'b0; cycles(4);
  endtask

  task automatic start();
    ena_i = 1'b1; ctl_i = 1'b1; cycles(10);
  endtask

  task automatic stop();
    ena_i = 1'b0; ctl_i = 1'b0; cycles(12);
  endtask

  // count low-low cycles from the fall of one command to the rise of the other
  task automatic gap(input bit from_gate, output int n);
    int guard = 0;
    n = 0;
    while ((from_gate ? gate_o : clamp_o) && guard < 60) begin
      @(negedge clk_i); guard++;
    end
    while (!(from_gate ? clamp_o : gate_o) && guard < 60) begin
      n++; @(negedge clk_i); guard++;
    end
  endtask

  task automatic t_reset();
    check("R1 gate at reset", gate_o, 0);
    check("R1 clamp at reset", clamp_o, 0);
    check("R1 ref at reset", ref_o, 0);
    check("R1 loop at reset", loop_o, 1);
  endtask

  task automatic t_default_mode();
    wr(3'd0, PK_LO); wr(3'd2, PK_HI); wr(3'd3, HD_LO); wr(3'd4, HD_HI);
    wr(3'd5, 8'd0);
    pclk_i = 1'b1;
    start();
    check("R3 default clock mode picks hold with zero dwell", ref_o, HD_LO);
    check("R6 clamp on with no request", clamp_o, 1);
    stop();
    pclk_i = 1'b0;
  endtask

  task automatic t_dwell();
    wr(3'd5, 8'd3);
    start();
    check("R4 peak lower level at start", ref_o, PK_LO);
    pulse_pclk(); pulse_pclk();
    check("R4 peak kept before last dwell edge", ref_o, PK_LO);
    pulse_pclk();
    check("R4 hold lower level after dwell", ref_o, HD_LO);
    pulse_pclk();
    check("R4 hold kept after extra edge", ref_o, HD_LO);
  endtask

  task automatic t_disable();
    cur_below_i = 1'b1; cycles(10);
    check("R6 gate on when below", gate_o, 1);
    check("R6 hold upper level with request", ref_o, HD_HI);
    @(negedge clk_i);
    ctl_i = 1'b0; #1;
    check("R2 gate drops at once with ctl low", gate_o, 0);
    cycles(12);
    check("R10 gate low after end", gate_o, 0);
    check("R10 clamp low after end", clamp_o, 0);
    ena_i = 1'b0; ctl_i = 1'b1; cycles(12);
    check("R2 no gate with ena low", gate_o, 0);
    ena_i = 1'b1; cycles(10);
    check("R10 restart on peak upper level", ref_o, PK_HI);
    pulse_pclk(); pulse_pclk();
    check("R10 full dwell reloaded", ref_o, PK_HI);
    pulse_pclk();
    check("R10 hold after full dwell", ref_o, HD_HI);
    cur_below_i = 1'b0;
    stop();
  endtask

  task automatic t_level();
    wr(3'd1, 8'h08);
    pclk_i = 1'b1;
    start();
    check("R5 level high picks peak", ref_o, PK_LO);
    pclk_i = 1'b0; cycles(8);
    check("R5 level low picks hold", ref_o, HD_LO);
    pclk_i = 1'b1; cycles(8);
    check("R5 level high again picks peak", ref_o, PK_LO);
    stop();
    pclk_i = 1'b0;
  endtask

  task automatic t_dead();
    int n;
    wr(3'd1, 8'h05); wr(3'd5, 8'd0);
    start();
    cur_below_i = 1'b1;
    gap(1'b0, n);
    check("R7 clamp to gate gap dead=5", n, 6);
    cycles(4);
    cur_below_i = 1'b0;
    gap(1'b1, n);
    check("R7 gate to clamp gap dead=5", n, 6);
    stop();
    wr(3'd1, 8'h00);
    start();
    cur_below_i = 1'b1;
    gap(1'b0, n);
    check("R7 clamp to gate gap dead=0", n, 1);
    cycles(4);
    cur_below_i = 1'b0;
    gap(1'b1, n);
    check("R7 gate to clamp gap dead=0", n, 1);
    stop();
  endtask

  task automatic t_loop();
    @(negedge clk_i);
    cur_below_i = 1'b1;
    @(negedge clk_i);
    check("R9 loop after one edge", loop_o, 1);
    @(negedge clk_i);
    check("R9 loop after two edges", loop_o, 0);
    cur_below_i = 1'b0;
    cycles(2);
    check("R9 loop back high", loop_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rst_ni = 1'b1;
    cycles(4);
    t_reset();
    t_default_mode();
    t_dwell();
    t_disable();
    t_level();
    t_dead();
    t_loop();
    check("R8 gate and clamp overlap count", overlaps, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule